// File: doc/BRIEF.md
# Serial Flash Continuous-Read Front End

This block is the device-side command decoder of a serial flash that lets a host execute code directly out of flash memory. It oversamples chip select, the serial clock and four IO lines on a fast system clock, finds rising serial-clock edges, and assembles the opcode, the 24-bit address and the trailing mode byte of the dual and quad I/O read commands. When a read's frame is complete it emits a one-cycle start strobe along with the decoded read kind and the address, for the array and data-return logic that sits downstream.

The mode byte sets a persistent continuous-read flag. While this flag is set, every new chip-select window skips the opcode and begins at the address. The read kind stays the one from the last opcode. The flag survives any number of idle chip-select periods. Only two things clear it: a completed mode byte whose continue field carries any other value, or a frame of all ones sent while the flag is set. That frame is 8 serial clocks on a four-lane read and 16 on a two-lane read. The block reports it with its own pulse instead of a start strobe. Because the flash has no reset pin, a host that has just restarted sends this all-ones frame first.

Top module: `xip_front`

## Requirements
- R1: Opcodes are sampled most significant bit first on io[0] at rising serial-clock edges, with the clock idling low or high. The opcode codes BBh, EBh, E7h and E3h select the rd_kind values 1 (two-lane), 2 (four-lane), 3 (four-lane word) and 4 (four-lane octal word). Any other opcode produces no start strobe for the rest of that chip-select window. rd_kind is 0 after reset.
- R2: After the opcode, the address and mode byte are shifted in most significant bits first. A two-lane read takes 2 bits per clock with io[1] the more significant lane: 12 address clocks, then 4 mode clocks. A four-lane read takes 4 bits per clock with io[3] the most significant lane: 6 address clocks, then 2 mode clocks. rd_addr presents the 24-bit address.
- R3: rd_start is a one-cycle pulse. It appears on the second system-clock edge after the rising serial-clock edge that completes the mode byte, and rd_kind and rd_addr are updated in the same cycle.
- R4: A completed mode byte whose bits 5..4 equal 2'b10 sets cont_mode. The next chip-select window then starts at the address, uses the same read kind, and needs no opcode. cont_mode holds across idle chip-select periods.
- R5: A completed mode byte whose bits 5..4 are 2'b00, 2'b01 or 2'b11 clears cont_mode, and the next window needs an opcode again.
- R6: Mode bits 7..6 and 3..0 have no effect on cont_mode or on any output.
- R7: While cont_mode is set on a four-lane read, 8 serial clocks with io[3:0] all ones clear cont_mode and pulse mode_clear, with no rd_start. The same bits in a window that began with an opcode form an ordinary read.
- R8: While cont_mode is set on a two-lane read, 16 all-ones serial clocks are needed to clear it. A window of only 8 all-ones clocks leaves cont_mode set and gives no pulse.
- R9: Chip select rising before the mode byte is complete abandons the window. It produces no strobe and leaves cont_mode unchanged.
- R10: The synchronous reset clears rd_start, mode_clear, cont_mode, rd_kind and rd_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial bus |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from the host |
| io | input | 4 | Serial data lanes, io[0] carries opcodes |
| rd_start | output | 1 | One-cycle pulse: a read frame is complete |
| rd_kind | output | 3 | Read kind of the last started read (0 none, 1 to 4) |
| rd_addr | output | 24 | Address of the last started read |
| cont_mode | output | 1 | Continuous-read flag: next window skips the opcode |
| mode_clear | output | 1 | One-cycle pulse: all-ones frame left continuous mode |

## Verification
Two functions close a frame on the same serial-clock edge: decoding the mode byte (start strobe and flag update) and detecting the all-ones exit frame. The bench drives all-ones frames in both states. In continuous mode the exit pulse must appear and the strobe must not. After an explicit opcode the strobe must appear and the exit pulse must not. A behavioural model compares every output on every system clock, and a bus-width mismatch in the exit count is provoked with a half-length two-lane burst.

// File: rtl/xip_pkg.sv
package xip_pkg;
  typedef enum logic [2:0] {
    RD_NONE  = 3'd0,
    RD_DUAL  = 3'd1,
    RD_QUAD  = 3'd2,
    RD_WORD  = 3'd3,
    RD_OCTAL = 3'd4
  } rd_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_OPC,
    ST_FRAME,
    ST_HOLD
  } ph_e;

  typedef enum logic [1:0] {
    LN_ONE,
    LN_TWO,
    LN_FOUR
  } lane_e;
endpackage

// File: rtl/xip_edge.sv
// Registers the serial bus into the system clock domain and flags
// a rising serial-clock edge inside an active chip-select window.
module xip_edge #(
  parameter int IO_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sclk,
  input  logic            cs_n,
  input  logic [IO_W-1:0] io,
  output logic            sel,
  output logic            rise,
  output logic [IO_W-1:0] io_s
);
  logic sclk_s;
  logic sclk_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_s <= 1'b0;
      sclk_p <= 1'b0;
      sel    <= 1'b0;
      io_s   <= '0;
    end else begin
      sclk_s <= sclk;
      sclk_p <= sclk_s;
      sel    <= ~cs_n;
      io_s   <= io;
    end
  end

  assign rise = sclk_s & ~sclk_p & sel;
endmodule

// File: rtl/xip_opdec.sv
// Maps an opcode to the read kind it starts; unknown codes give RD_NONE.
module xip_opdec
  import xip_pkg::*;
#(
  parameter int             OPC_W    = 8,
  parameter logic [OPC_W-1:0] OP_DUAL  = 8'hBB,
  parameter logic [OPC_W-1:0] OP_QUAD  = 8'hEB,
  parameter logic [OPC_W-1:0] OP_WORD  = 8'hE7,
  parameter logic [OPC_W-1:0] OP_OCTAL = 8'hE3
) (
  input  logic [OPC_W-1:0] op,
  output rd_kind_e         kind
);
  always_comb begin
    if (op == OP_DUAL)       kind = RD_DUAL;
    else if (op == OP_QUAD)  kind = RD_QUAD;
    else if (op == OP_WORD)  kind = RD_WORD;
    else if (op == OP_OCTAL) kind = RD_OCTAL;
    else                     kind = RD_NONE;
  end
endmodule

// File: rtl/xip_shift.sv
// Collects 1, 2 or 4 bits per serial clock, counts clocks and tracks
// whether every sampled bit so far has been one.
module xip_shift
  import xip_pkg::*;
#(
  parameter int FRAME_W = 32,
  parameter int IO_W    = 4,
  localparam int CW     = $clog2(FRAME_W + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               rise,
  input  lane_e              lanes,
  input  logic [IO_W-1:0]    io,
  output logic [FRAME_W-1:0] data_nxt,
  output logic               ones_nxt,
  output logic [CW-1:0]      cnt
);
  logic [FRAME_W-1:0] data_q;
  logic               ones_q;

  always_comb begin
    unique case (lanes)
      LN_ONE: begin
        data_nxt = {data_q[FRAME_W-2:0], io[0]};
        ones_nxt = ones_q & io[0];
      end
      LN_TWO: begin
        data_nxt = {data_q[FRAME_W-3:0], io[1:0]};
        ones_nxt = ones_q & (&io[1:0]);
      end
      default: begin
        data_nxt = {data_q[FRAME_W-5:0], io[3:0]};
        ones_nxt = ones_q & (&io[3:0]);
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      data_q <= '0;
      ones_q <= 1'b1;
      cnt    <= '0;
    end else if (rise) begin
      data_q <= data_nxt;
      ones_q <= ones_nxt;
      cnt    <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/xip_front.sv
// Device-side command front end for dual/quad continuous reads.
module xip_front
  import xip_pkg::*;
#(
  parameter int             ADDR_W   = 24,
  parameter int             MODE_W   = 8,
  parameter int             OPC_W    = 8,
  parameter int             CONT_LSB = 4,
  parameter logic [1:0]     CONT_KEY = 2'b10,
  parameter logic [OPC_W-1:0] OP_DUAL  = 8'hBB,
  parameter logic [OPC_W-1:0] OP_QUAD  = 8'hEB,
  parameter logic [OPC_W-1:0] OP_WORD  = 8'hE7,
  parameter logic [OPC_W-1:0] OP_OCTAL = 8'hE3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic [3:0]        io,
  output logic              rd_start,
  output logic [2:0]        rd_kind,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              cont_mode,
  output logic              mode_clear
);
  localparam int IO_W    = 4;
  localparam int FRAME_W = ADDR_W + MODE_W;
  localparam int CW      = $clog2(FRAME_W + 1);
  localparam logic [CW-1:0] OPC_LAST  = CW'(OPC_W - 1);
  localparam logic [CW-1:0] DUAL_LAST = CW'(FRAME_W / 2 - 1);
  localparam logic [CW-1:0] QUAD_LAST = CW'(FRAME_W / 4 - 1);

  logic               sel;
  logic               rise;
  logic [IO_W-1:0]    io_s;
  ph_e                ph_q;
  rd_kind_e           kind_q;
  rd_kind_e           op_kind;
  logic               from_cont_q;
  lane_e              lanes;
  logic [CW-1:0]      last_cnt;
  logic [CW-1:0]      cnt;
  logic               hit;
  logic               clr;
  logic [FRAME_W-1:0] data_nxt;
  logic               ones_nxt;
  logic [1:0]         cont_key;

  xip_edge #(.IO_W(IO_W)) u_edge (
    .clk  (clk),
    .rst  (rst),
    .sclk (sclk),
    .cs_n (cs_n),
    .io   (io),
    .sel  (sel),
    .rise (rise),
    .io_s (io_s)
  );

  xip_shift #(.FRAME_W(FRAME_W), .IO_W(IO_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr),
    .rise     (rise),
    .lanes    (lanes),
    .io       (io_s),
    .data_nxt (data_nxt),
    .ones_nxt (ones_nxt),
    .cnt      (cnt)
  );

  xip_opdec #(
    .OPC_W   (OPC_W),
    .OP_DUAL (OP_DUAL),
    .OP_QUAD (OP_QUAD),
    .OP_WORD (OP_WORD),
    .OP_OCTAL(OP_OCTAL)
  ) u_opdec (
    .op   (data_nxt[OPC_W-1:0]),
    .kind (op_kind)
  );

  always_comb begin
    if (ph_q == ST_OPC) begin
      lanes    = LN_ONE;
      last_cnt = OPC_LAST;
    end else if (kind_q == RD_DUAL) begin
      lanes    = LN_TWO;
      last_cnt = DUAL_LAST;
    end else begin
      lanes    = LN_FOUR;
      last_cnt = QUAD_LAST;
    end
  end

  assign hit      = rise && (cnt == last_cnt);
  assign clr      = (ph_q == ST_IDLE) || ((ph_q == ST_OPC) && hit);
  assign cont_key = data_nxt[CONT_LSB+1:CONT_LSB];

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q        <= ST_IDLE;
      kind_q      <= RD_NONE;
      from_cont_q <= 1'b0;
      cont_mode   <= 1'b0;
      rd_start    <= 1'b0;
      mode_clear  <= 1'b0;
      rd_kind     <= RD_NONE;
      rd_addr     <= '0;
    end else begin
      rd_start   <= 1'b0;
      mode_clear <= 1'b0;
      if (!sel) begin
        ph_q <= ST_IDLE;
      end else begin
        unique case (ph_q)
          ST_IDLE: begin
            from_cont_q <= cont_mode;
            ph_q        <= cont_mode ? ST_FRAME : ST_OPC;
          end
          ST_OPC: begin
            if (hit) begin
              if (op_kind == RD_NONE) begin
                ph_q <= ST_HOLD;
              end else begin
                kind_q      <= op_kind;
                from_cont_q <= 1'b0;
                ph_q        <= ST_FRAME;
              end
            end
          end
          ST_FRAME: begin
            if (hit) begin
              ph_q <= ST_HOLD;
              if (from_cont_q && ones_nxt) begin
                cont_mode  <= 1'b0;
                mode_clear <= 1'b1;
              end else begin
                rd_start  <= 1'b1;
                rd_addr   <= data_nxt[FRAME_W-1:MODE_W];
                rd_kind   <= kind_q;
                cont_mode <= (cont_key == CONT_KEY);
              end
            end
          end
          default: ph_q <= ST_HOLD;
        endcase
      end
    end
  end
endmodule

// File: rtl/xip_front_chk.sv
module xip_front_chk (
  input logic       clk,
  input logic       rst,
  input logic       rd_start,
  input logic [2:0] rd_kind,
  input logic       cont_mode,
  input logic       mode_clear
);
  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rd_start |=> !rd_start); // R3
  AST_KIND_ON_START: assert property (@(posedge clk) disable iff (rst)
    rd_start |-> (rd_kind != 3'd0)); // R1
  AST_CLEAR_NOT_START: assert property (@(posedge clk) disable iff (rst)
    !(rd_start && mode_clear)); // R7
  AST_CLEAR_DROPS_CONT: assert property (@(posedge clk) disable iff (rst)
    mode_clear |-> !cont_mode); // R7
  AST_CLEAR_FROM_CONT: assert property (@(posedge clk) disable iff (rst)
    mode_clear |-> $past(cont_mode)); // R8
  AST_CONT_ONLY_ON_FRAME: assert property (@(posedge clk) disable iff (rst)
    !$stable(cont_mode) |-> (rd_start || mode_clear)); // R9
endmodule

bind xip_front xip_front_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .rd_start   (rd_start),
  .rd_kind    (rd_kind),
  .cont_mode  (cont_mode),
  .mode_clear (mode_clear)
);

// File: tb/xip_front_test.sv
`timescale 1ns/1ps
module xip_front_test;
  localparam int HP = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1;
  logic        sclk = 1'b0;
  logic [3:0]  io = 4'h0;
  logic        rd_start;
  logic [2:0]  rd_kind;
  logic [23:0] rd_addr;
  logic        cont_mode;
  logic        mode_clear;

  int n_chk = 0;
  int n_fail = 0;
  int n_start = 0;
  int n_clear = 0;
  logic [23:0] last_addr = '0;
  bit done = 0;

  always #10 clk = ~clk;

  xip_front uut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .io(io),
    .rd_start(rd_start), .rd_kind(rd_kind), .rd_addr(rd_addr),
    .cont_mode(cont_mode), .mode_clear(mode_clear)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  bit m_sclk_s = 0, m_sclk_p = 0, m_sel = 0;
  bit [3:0] m_io = 0;
  int ph = 0, cnt = 0, cur = 0, e_kind = 0;
  bit [31:0] acc = 0;
  bit ones = 1, from_c = 0, cont = 0, e_start = 0, e_clear = 0;
  bit [23:0] e_addr = 0;

  always @(posedge clk) begin : model
    bit rise;
    int ln, kind;
    bit [3:0] mask;
    rise = m_sclk_s && !m_sclk_p && m_sel;
    if (rst) begin
      ph = 0; cur = 0; e_kind = 0; cont = 0; from_c = 0;
      e_start = 0; e_clear = 0; e_addr = 0;
      m_sclk_s = 0; m_sclk_p = 0; m_sel = 0; m_io = 0;
    end else begin
      e_start = 0; e_clear = 0;
      if (!m_sel) ph = 0;
      else if (ph == 0) begin
        from_c = cont; ph = cont ? 2 : 1; cnt = 0; acc = 0; ones = 1;
      end else if (ph == 1 && rise) begin
        acc = {acc[30:0], m_io[0]};
        cnt++;
        if (cnt == 8) begin
          case (acc[7:0])
            8'hBB: kind = 1;
            8'hEB: kind = 2;
            8'hE7: kind = 3;
            8'hE3: kind = 4;
            default: kind = 0;
          endcase
          if (kind == 0) ph = 3;
          else begin
            cur = kind; ph = 2; cnt = 0; acc = 0; ones = 1; from_c = 0;
          end
        end
      end else if (ph == 2 && rise) begin
        ln = (cur == 1) ? 2 : 4;
        mask = (ln == 2) ? 4'h3 : 4'hF;
        acc = (acc << ln) | 32'(m_io & mask);
        if ((m_io & mask) != mask) ones = 0;
        cnt++;
        if (cnt == 32 / ln) begin
          ph = 3;
          if (from_c && ones) begin
            e_clear = 1; cont = 0;
          end else begin
            e_start = 1; e_addr = acc[31:8]; e_kind = cur;
            cont = (acc[5:4] == 2'b10);
          end
        end
      end
      m_sclk_p = m_sclk_s; m_sclk_s = sclk; m_sel = !cs_n; m_io = io;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R3 rd_start", rd_start, e_start);
      check("R4 cont_mode", cont_mode, cont);
      check("R7 mode_clear", mode_clear, e_clear);
      check("R1 rd_kind", rd_kind, e_kind);
      if (e_start) check("R2 rd_addr", rd_addr, e_addr);
      if (rd_start) begin n_start++; last_addr = rd_addr; end
      if (mode_clear) n_clear++;
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sck(input logic [3:0] v);
    sclk = 1'b0; io = v; wait_clk(HP);
    sclk = 1'b1; wait_clk(HP);
  endtask

  task automatic open_tx(input bit idle_hi);
    sclk = idle_hi; wait_clk(2);
    cs_n = 1'b0; wait_clk(3);
  endtask

  task automatic close_tx(input bit idle_hi);
    if (!idle_hi) begin sclk = 1'b0; wait_clk(2); end
    cs_n = 1'b1; io = 4'h0; wait_clk(4);
    sclk = 1'b0; wait_clk(2);
  endtask

  task automatic send_op(input logic [7:0] op);
    for (int i = 7; i >= 0; i--) sck({3'b000, op[i]});
  endtask

  task automatic send_frame(input bit dual, input logic [23:0] a, input logic [7:0] m);
    logic [31:0] f;
    f = {a, m};
    if (dual) for (int i = 15; i >= 0; i--) sck({2'b00, f[2*i+1 -: 2]});
    else      for (int i = 7; i >= 0; i--)  sck(f[4*i+3 -: 4]);
  endtask

  task automatic full_read(input bit idle_hi, input logic [7:0] op, input bit dual,
                           input logic [23:0] a, input logic [7:0] m);
    open_tx(idle_hi); send_op(op); send_frame(dual, a, m); close_tx(idle_hi);
  endtask

  task automatic cont_read(input bit dual, input logic [23:0] a, input logic [7:0] m);
    open_tx(1'b0); send_frame(dual, a, m); close_tx(1'b0);
  endtask

  task automatic ones_burst(input int n);
    open_tx(1'b0);
    repeat (n) sck(4'hF);
    close_tx(1'b0);
  endtask

  initial begin : watchdog
    wait_clk(150000);
    if (!done) begin
      n_fail++;
      $display("FAIL R3 watchdog actual=hung expected=done");
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : stim
    int s0;
    wait_clk(5);
    // R10 reset state
    check("R10 rd_start", rd_start, 0);
    check("R10 cont_mode", cont_mode, 0);
    check("R10 rd_kind", rd_kind, 0);
    check("R10 rd_addr", rd_addr, 0);
    check("R10 mode_clear", mode_clear, 0);
    rst = 1'b0;
    wait_clk(4);

    // R1 R2 R4 quad read entering continuous mode
    full_read(1'b0, 8'hEB, 1'b0, 24'h123456, 8'h20);
    check("R1 quad kind", rd_kind, 2);
    check("R2 quad addr", last_addr, 24'h123456);
    check("R4 cont set", cont_mode, 1);

    // R6 R4 opcode-less read, reserved mode bits all set
    cont_read(1'b0, 24'hABCDEF, 8'hEF);
    check("R6 cont kept", cont_mode, 1);
    check("R4 no-opcode addr", last_addr, 24'hABCDEF);
    check("R4 start count", n_start, 2);

    // R7 quad exit burst
    ones_burst(8);
    check("R7 cont cleared", cont_mode, 0);
    check("R7 clear count", n_clear, 1);
    check("R7 no start", n_start, 2);

    // R5 dual read, mode 3 idle, key 01
    full_read(1'b1, 8'hBB, 1'b1, 24'h00FF00, 8'h10);
    check("R5 cont off", cont_mode, 0);
    check("R1 dual kind", rd_kind, 1);
    check("R2 dual addr", last_addr, 24'h00FF00);

    // R4 dual into continuous, then opcode-less dual
    full_read(1'b0, 8'hBB, 1'b1, 24'hA5A5A5, 8'hA0);
    check("R4 dual cont", cont_mode, 1);
    cont_read(1'b1, 24'h3C3C3C, 8'h6F);
    check("R6 dual cont kept", cont_mode, 1);
    check("R2 dual cont addr", last_addr, 24'h3C3C3C);

    // R8 half burst does not exit, full burst does
    ones_burst(8);
    check("R8 half burst keeps cont", cont_mode, 1);
    check("R8 half burst no clear", n_clear, 1);
    ones_burst(16);
    check("R8 full burst clears", cont_mode, 0);
    check("R8 clear count", n_clear, 2);

    // R9 abort in normal mode
    s0 = n_start;
    open_tx(1'b0); send_op(8'hE7); repeat (3) sck(4'h5); close_tx(1'b0);
    check("R9 abort no start", n_start, s0);
    check("R9 abort cont", cont_mode, 0);

    // R9 abort in continuous mode
    full_read(1'b0, 8'hE3, 1'b0, 24'h010203, 8'h20);
    check("R1 octal kind", rd_kind, 4);
    open_tx(1'b0); repeat (4) sck(4'hF); close_tx(1'b0);
    check("R9 cont survives abort", cont_mode, 1);
    cont_read(1'b0, 24'h0A0B0C, 8'h00);
    check("R5 key 00 clears", cont_mode, 0);
    check("R2 octal addr", last_addr, 24'h0A0B0C);

    // R1 unknown opcode
    s0 = n_start;
    open_tx(1'b0); send_op(8'h03); repeat (8) sck(4'hF); close_tx(1'b0);
    check("R1 unknown opcode", n_start, s0);

    // R7 all ones after an opcode is an ordinary read
    s0 = n_clear;
    full_read(1'b0, 8'hEB, 1'b0, 24'hFFFFFF, 8'hFF);
    check("R7 opcode ones no clear", n_clear, s0);
    check("R7 opcode ones addr", last_addr, 24'hFFFFFF);

    // R6 reserved bits with key 01
    full_read(1'b0, 8'hE7, 1'b0, 24'h000001, 8'hDF);
    check("R6 key 01 reserved set", cont_mode, 0);
    check("R1 word kind", rd_kind, 3);

    wait_clk(4);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule